// File: doc/BRIEF.md
# Clock-Synchronous Serial Port with Receive-Ready Handshake

This block moves one 8-bit word at a time over a clocked serial link. Software writes a mode register and then the data register. The write to the data register starts a transfer. While the word shifts out on the data output, the incoming line is shifted into the same register. When the last bit is in, the block raises a one-cycle interrupt pulse, and the received word can be read back through the register bus.

The shift clock comes from one of two places. It can be made inside the block from the system clock, divided by 4, 16, 32 or 64. It can also come from outside on the clock pin. In that case it is first synchronised to the system clock, and its rate must stay below a quarter of the system clock rate.

A ready output gives a simple handshake to the partner. It goes low right after a data write and goes high again at the first falling edge of the shift clock. A loopback mode takes the received bit from the block's own output line instead of the input pin, for use on a shared half-duplex wire.

Top module: `sioPort`

## Requirements
- R1: A write to the data register (busAddr=0) loads the shift register and sets the bit counter to 7. On the next cycle the internal shift clock reads high. A write during a transfer restarts it from the first bit, and that restarted transfer gives exactly one interrupt.
- R2: srdyOut is low from the cycle after a data write. It returns high at the first falling edge of the shift clock.
- R3: soutPin changes only at falling edges of the shift clock. The input bit is sampled, and the register shifts by one place, at rising edges. The word written is sent on soutPin and the word read back is the one received.
- R4: With the internal clock (mode bit 2 = 0), after 8 rising edges the shift clock stops and stays high. irqOut is high for exactly one cycle.
- R5: Mode bits [1:0] choose the internal shift-clock period in system cycles: 00 gives 4, 01 gives 16, 10 gives 32, 11 gives 64.
- R6: Mode bit 3 = 0 sends and receives least significant bit first. Mode bit 3 = 1 sends and receives most significant bit first.
- R7: With the internal clock, soutOe is high only while a transfer is running. It is low when idle and low after completion. sclkOe is 1 in internal mode and 0 in external mode.
- R8: With an external clock (mode bit 2 = 1), sclkIn is synchronised and never gated. soutOe stays 1. After 8 rising edges irqOut pulses once. Any further edges keep shifting data without another interrupt until the next data write.
- R9: Mode bit 4 = 1 takes the input bit from the port's own output line and ignores sinPin, so the word read back equals the word sent.
- R10: After reset the following hold: mode register 0, data register 0, srdyOut 1, sclkOut 1, sclkOe 1, soutOe 0 and irqOut 0.
- R11: A bus read at busAddr=0 returns the shift register. A read at busAddr=1 returns the mode register in bits [4:0], with the upper bits reading 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 1 | Register select: 0 data, 1 mode |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for the selected register |
| sclkIn | input | 1 | External shift clock input |
| sclkOut | output | 1 | Internally generated shift clock |
| sclkOe | output | 1 | Drive enable for the shift clock pin |
| sinPin | input | 1 | Serial data input |
| soutPin | output | 1 | Serial data output |
| soutOe | output | 1 | Drive enable for the serial output |
| srdyOut | output | 1 | Receive-ready handshake output |
| irqOut | output | 1 | One-cycle transfer-done pulse |

## Verification
The assertions assume that the mode register is not rewritten while a transfer is running. They also assume that sclkIn idles high and changes no faster than one level every several system cycles.

The bench writes the mode register only between transfers. It moves sinPin only just after a falling shift-clock edge, so the input is stable across each sampling edge. It holds each external clock level for 8 system cycles, well beyond the synchroniser delay.

// File: rtl/sio_pkg.sv
package sio_pkg;

  localparam int MODE_W = 5;

  typedef struct packed {
    logic load;      // parallel load from the bus
    logic shiftOut;  // falling edge: present next output bit
    logic shiftIn;   // rising edge: capture input bit and shift
  } sioStrobe_t;

  // half period of the internal shift clock, in system cycles
  function automatic int halfCount(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2;
      2'd1:    return 8;
      2'd2:    return 16;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/sioCtrl.sv
module sioCtrl
  import sio_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dataWr,
  input  logic       extMode,
  input  logic [1:0] divSel,
  input  logic       sclkIn,
  output sioStrobe_t strobe,
  output logic       sclkOut,
  output logic       sclkOe,
  output logic       soutOe,
  output logic       srdyOut,
  output logic       irqOut
);

  localparam int BIT_W = $clog2(DATA_W);
  localparam int CNT_W = 6;

  logic [BIT_W-1:0]       bitCnt;
  logic [CNT_W-1:0]       divCnt;
  logic [CNT_W-1:0]       halfLim;
  logic                   sclkReg;
  logic                   active;
  logic                   pending;
  logic                   srdyReg;
  logic                   irqReg;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   extPrev;
  logic                   extRise;
  logic                   extFall;
  logic                   intTick;

  assign halfLim = CNT_W'(halfCount(divSel) - 1);

  // external clock synchroniser, idles high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '1;
      extPrev <= 1'b1;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], sclkIn};
      extPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  assign extRise = extMode && syncQ[SYNC_STAGES-1] && !extPrev;
  assign extFall = extMode && !syncQ[SYNC_STAGES-1] && extPrev;
  assign intTick = !extMode && active && (divCnt == halfLim) && !dataWr;

  always_comb begin
    strobe.load     = dataWr;
    strobe.shiftOut = !dataWr && ((intTick && sclkReg) || extFall);
    strobe.shiftIn  = !dataWr && ((intTick && !sclkReg) || extRise);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkReg <= 1'b1;
      bitCnt  <= '0;
      divCnt  <= '0;
      active  <= 1'b0;
      pending <= 1'b0;
      srdyReg <= 1'b1;
      irqReg  <= 1'b0;
    end else begin
      irqReg <= 1'b0;
      if (dataWr) begin
        sclkReg <= 1'b1;
        bitCnt  <= BIT_W'(DATA_W - 1);
        divCnt  <= '0;
        active  <= !extMode;
        pending <= 1'b1;
        srdyReg <= 1'b0;
      end else if (!extMode) begin
        if (active) begin
          if (divCnt == halfLim) begin
            divCnt  <= '0;
            sclkReg <= !sclkReg;
            if (sclkReg) begin
              srdyReg <= 1'b1;
            end else if (bitCnt == '0) begin
              active  <= 1'b0;
              pending <= 1'b0;
              irqReg  <= 1'b1;
            end else begin
              bitCnt <= bitCnt - 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
      end else begin
        active  <= 1'b0;
        sclkReg <= 1'b1;
        if (extFall) srdyReg <= 1'b1;
        if (extRise && pending) begin
          if (bitCnt == '0) begin
            pending <= 1'b0;
            irqReg  <= 1'b1;
          end else begin
            bitCnt <= bitCnt - 1'b1;
          end
        end
      end
    end
  end

  assign sclkOut = sclkReg;
  assign sclkOe  = !extMode;
  assign soutOe  = extMode || active;
  assign srdyOut = srdyReg;
  assign irqOut  = irqReg;

  AST_LOAD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    dataWr && !extMode |=> sclkReg && active && (bitCnt == BIT_W'(DATA_W - 1))); // R1
  AST_SRDY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> !srdyReg); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.shiftIn && strobe.shiftOut)); // R3
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    irqReg && !extMode |-> sclkReg && !active && !soutOe); // R4
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    irqReg |=> !irqReg); // R4
  AST_EXT_NO_EXTRA_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    extMode && !pending && !dataWr |=> !irqReg); // R8

endmodule

// File: rtl/sioData.sv
module sioData
  import sio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sioStrobe_t        strobe,
  input  logic              msbFirst,
  input  logic              commonMode,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sinPin,
  output logic [DATA_W-1:0] shReg,
  output logic              soutBit
);

  logic inBit;

  assign inBit = commonMode ? soutBit : sinPin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      soutBit <= 1'b1;
    end else if (strobe.load) begin
      shReg <= wrData;
    end else begin
      if (strobe.shiftOut)
        soutBit <= msbFirst ? shReg[DATA_W-1] : shReg[0];
      if (strobe.shiftIn) begin
        if (msbFirst) shReg <= {shReg[DATA_W-2:0], inBit};
        else          shReg <= {inBit, shReg[DATA_W-1:1]};
      end
    end
  end

  AST_SOUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftOut |=> $stable(soutBit)); // R3
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftIn && !strobe.load |=> $stable(shReg)); // R3

endmodule

// File: rtl/sioPort.sv
module sioPort
  import sio_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              sclkIn,
  output logic              sclkOut,
  output logic              sclkOe,
  input  logic              sinPin,
  output logic              soutPin,
  output logic              soutOe,
  output logic              srdyOut,
  output logic              irqOut
);

  logic [MODE_W-1:0] modeReg;
  logic [DATA_W-1:0] shReg;
  logic              dataWr;
  sioStrobe_t        strobe;

  assign dataWr = busWr && !busAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               modeReg <= '0;
    else if (busWr && busAddr) modeReg <= busWrData[MODE_W-1:0];
  end

  sioCtrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) ctrl (
    .clk(clk), .rstN(rstN), .dataWr(dataWr), .extMode(modeReg[2]),
    .divSel(modeReg[1:0]), .sclkIn(sclkIn), .strobe(strobe),
    .sclkOut(sclkOut), .sclkOe(sclkOe), .soutOe(soutOe),
    .srdyOut(srdyOut), .irqOut(irqOut)
  );

  sioData #(.DATA_W(DATA_W)) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .msbFirst(modeReg[3]),
    .commonMode(modeReg[4]), .wrData(busWrData), .sinPin(sinPin),
    .shReg(shReg), .soutBit(soutPin)
  );

  assign busRdData = busAddr ? {{(DATA_W-MODE_W){1'b0}}, modeReg} : shReg;

endmodule

// File: tb/sioPort_test.sv
module sioPort_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWr = 1'b0;
  logic       busAddr = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       sclkIn = 1'b1;
  logic       sclkOut, sclkOe, soutPin, soutOe, srdyOut, irqOut;
  logic       sinPin = 1'b0;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  sioPort uut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .sclkIn(sclkIn),
    .sclkOut(sclkOut), .sclkOe(sclkOe), .sinPin(sinPin), .soutPin(soutPin),
    .soutOe(soutOe), .srdyOut(srdyOut), .irqOut(irqOut)
  );

  // {mode, txData, sinData}
  localparam logic [23:0] VEC [6] = '{
    {8'h00, 8'hA5, 8'h3C},
    {8'h01, 8'h81, 8'h7E},
    {8'h0A, 8'h1E, 8'hC3},
    {8'h0B, 8'hF0, 8'h96},
    {8'h10, 8'h5A, 8'h00},
    {8'h18, 8'hC9, 8'hFF}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic addr, input logic [7:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = addr; busWrData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic addr, output logic [7:0] d);
    @(negedge clk);
    busAddr = addr;
    #1 d = busRdData;
  endtask

  function automatic logic pickBit(input logic [7:0] w, input bit msb, input int i);
    return msb ? w[7-i] : w[i];
  endfunction

  // internal-clock transfer with checks
  task automatic runInt(input logic [7:0] mode, input logic [7:0] tx, input logic [7:0] sin);
    bit   msb = mode[3];
    int   half;
    int   t = 0, fallCnt = 0, riseCnt = 0, irqCnt = 0, fall0 = 0, fall1 = 0;
    logic prev = 1'b1;
    logic [7:0] seen = '0;
    logic [7:0] rd;
    logic [7:0] expRx;
    case (mode[1:0])
      2'd0: half = 2;
      2'd1: half = 8;
      2'd2: half = 16;
      default: half = 32;
    endcase
    expRx = mode[4] ? tx : sin;
    busWrite(1'b1, mode);
    busWrite(1'b0, tx);
    chk(sclkOut == 1'b1, "R1 clock forced high after write", sclkOut, 1);
    chk(srdyOut == 1'b0, "R2 ready low after write", srdyOut, 0);
    chk(soutOe == 1'b1, "R7 output driven during transfer", soutOe, 1);
    while (riseCnt < 8 && t < 3000) begin
      logic cur;
      if (t > 0) @(negedge clk);
      t++;
      if (irqOut) irqCnt++;
      cur = sclkOut;
      if (prev && !cur) begin
        if (fallCnt == 0) begin
          fall0 = t;
          chk(srdyOut == 1'b1, "R2 ready high at first fall", srdyOut, 1);
        end
        if (fallCnt == 1) fall1 = t;
        sinPin = pickBit(sin, msb, fallCnt);
        fallCnt++;
      end
      if (!prev && cur) begin
        seen[riseCnt] = soutPin;
        riseCnt++;
      end
      prev = cur;
    end
    chk(fall1 - fall0 == 2 * half, "R5 shift clock period", fall1 - fall0, 2 * half);
    for (int i = 0; i < 8; i++)
      chk(seen[i] == pickBit(tx, msb, i), "R3 R6 transmitted bit", seen[i], pickBit(tx, msb, i));
    repeat (2 * half + 4) begin
      @(negedge clk);
      if (irqOut) irqCnt++;
      if (sclkOut != 1'b1) chk(0, "R4 clock stopped high", sclkOut, 1);
    end
    chk(irqCnt == 1, "R4 single interrupt pulse", irqCnt, 1);
    chk(soutOe == 1'b0, "R7 output released after completion", soutOe, 0);
    busRead(1'b0, rd);
    chk(rd == expRx, mode[4] ? "R9 loopback receive" : "R3 R6 received word", rd, expRx);
  endtask

  task automatic extPulse(input logic sinVal, output logic soutSeen);
    @(negedge clk);
    sclkIn = 1'b0;
    sinPin = sinVal;
    repeat (8) @(negedge clk);
    soutSeen = soutPin;
    sclkIn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  int irqTotal = 0;
  always @(negedge clk) if (irqOut) irqTotal++;

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !ended) begin
      ended = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic       s;
    logic [7:0] seenTx;
    int         irqBase;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(srdyOut == 1'b1, "R10 ready after reset", srdyOut, 1);
    chk(sclkOut == 1'b1, "R10 clock after reset", sclkOut, 1);
    chk(sclkOe == 1'b1, "R10 clock drive after reset", sclkOe, 1);
    chk(soutOe == 1'b0, "R10 output drive after reset", soutOe, 0);
    chk(irqOut == 1'b0, "R10 interrupt after reset", irqOut, 0);
    busRead(1'b0, rd);
    chk(rd == 8'h00, "R10 data register after reset", rd, 0);
    busRead(1'b1, rd);
    chk(rd == 8'h00, "R10 mode register after reset", rd, 0);

    // R11 register read-back
    busWrite(1'b1, 8'hE7);
    busRead(1'b1, rd);
    chk(rd == 8'h07, "R11 mode read upper bits zero", rd, 8'h07);
    busWrite(1'b1, 8'h13);
    busRead(1'b1, rd);
    chk(rd == 8'h13, "R11 mode read", rd, 8'h13);
    busWrite(1'b1, 8'h00);
    busWrite(1'b0, 8'h00);
    repeat (40) @(negedge clk);

    // vector table walk
    for (int v = 0; v < 6; v++)
      runInt(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);

    // R1 restart during a transfer
    sinPin = 1'b1;
    busWrite(1'b1, 8'h03);
    busWrite(1'b0, 8'h00);
    repeat (100) @(negedge clk);
    irqBase = irqTotal;
    busWrite(1'b0, 8'h55);
    chk(sclkOut == 1'b1, "R1 restart forces clock high", sclkOut, 1);
    chk(srdyOut == 1'b0, "R1 restart drops ready", srdyOut, 0);
    repeat (600) @(negedge clk);
    chk(irqTotal - irqBase == 1, "R1 restart gives one interrupt", irqTotal - irqBase, 1);
    busRead(1'b0, rd);
    chk(rd == 8'hFF, "R1 restart full receive", rd, 8'hFF);

    // R8 external clock
    busWrite(1'b1, 8'h04);
    chk(sclkOe == 1'b0, "R7 clock not driven in external mode", sclkOe, 0);
    chk(soutOe == 1'b1, "R8 output driven in external mode", soutOe, 1);
    irqBase = irqTotal;
    busWrite(1'b0, 8'h6D);
    chk(srdyOut == 1'b0, "R2 ready low after write, external", srdyOut, 0);
    for (int i = 0; i < 8; i++) begin
      extPulse(pickBit(8'hB2, 1'b0, i), s);
      seenTx[i] = s;
      if (i == 0) chk(srdyOut == 1'b1, "R2 ready high after external fall", srdyOut, 1);
    end
    chk(seenTx == 8'h6D, "R8 external transmit", seenTx, 8'h6D);
    busRead(1'b0, rd);
    chk(rd == 8'hB2, "R8 external receive", rd, 8'hB2);
    chk(irqTotal - irqBase == 1, "R8 interrupt after 8 edges", irqTotal - irqBase, 1);
    for (int i = 0; i < 4; i++) extPulse(1'b1, s);
    busRead(1'b0, rd);
    chk(rd == 8'hFB, "R8 shifting continues past 8", rd, 8'hFB);
    chk(irqTotal - irqBase == 1, "R8 no extra interrupt", irqTotal - irqBase, 1);

    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule